// File: doc/BRIEF.md
# CCD Line Black-Level Corrector

This block sits after the analog-to-digital converter on one colour channel of a three-colour linear CCD. It takes one digitised sample per pixel clock, with a flag that marks the first sample of each line. It counts the samples within the line, which has a fixed length: a leading run of dummy positions, then the effective pixels, then a short trailing run of dummy positions. A small group of early dummy positions gives the dark reference for the line. Their mean is taken as the black level and is subtracted from every effective pixel of the same line.

Only the effective pixels leave the block. Each one carries a valid strobe, and the first one also carries a start-of-line flag. The three colours use three separate instances. The default line has 63 leading dummy positions, 7078 effective pixels and 12 trailing dummy positions, 7153 in all. The dark reference uses the 2nd through 12th dummy positions, 11 samples.

Top module: `ccd_black_level_corrector`

## Requirements
- R1: A sample with `in_valid` and `in_sol` high takes line index 0. Each later sample with `in_valid` high takes the next index. After index LINE_LEN-1 (7152 by default) the line is over. Samples without `in_sol` that arrive outside an open line are ignored.
- R2: Indices 0 to LEAD_DUMMY-1 are leading dummies. The next EFF_PIX indices are effective pixels. The last TRAIL_DUMMY indices are trailing dummies.
- R3: The black level is round(sum/N), with halves rounded up. Here sum is the total of the samples at indices BLK_FIRST-1 through BLK_LAST-1, and N = BLK_LAST-BLK_FIRST+1 (11 by default).
- R4: `out_black` shows the new black level from the clock edge after the sample at index BLK_LAST-1 is accepted.
- R5: The black level keeps its value until the index BLK_LAST-1 sample of a later line.
- R6: For an effective pixel, `out_data` is the input minus the current black level. It is clamped to 0 when the input is lower than the black level.
- R7: `out_valid` is high one cycle after each effective-pixel sample and at no other time. `out_sol` is high only alongside the first effective pixel (index LEAD_DUMMY).
- R8: An `in_sol` during an open line restarts the count at index 0. The rest of the interrupted line produces no output.
- R9: A cycle with `in_valid` low does not advance the index and produces no output.
- R10: After reset, `out_valid`, `out_sol`, `out_data` and `out_black` are 0 and no line is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_sol | input | 1 | This sample is the first of a line |
| in_data | input | DATA_W | Digitised pixel value |
| out_valid | output | 1 | Corrected effective pixel present |
| out_sol | output | 1 | Corrected pixel is the first effective pixel |
| out_data | output | DATA_W | Black-corrected pixel value |
| out_black | output | DATA_W | Black level of the latest completed reference window |

## Verification
The assertions run on every cycle. They check that the line index stays inside the line, that it restarts after a start flag, and that it stays still when no sample arrives. They also check that the black level moves only after the last reference sample, that a corrected pixel never exceeds its input, and that the start flag never appears without the valid strobe. Some behaviour shows only in the bench scenarios. The exact rounded quotient is checked across a sweep of reference sums that covers every remainder. The scenarios also show clamping at zero, that pixels outside the effective band stay hidden, that an interrupted line is abandoned, and that stray samples between lines are ignored.

// File: rtl/ccd_blc_pkg.sv
package ccd_blc_pkg;

    typedef enum logic [1:0] {
        REG_IDLE  = 2'd0,
        REG_LEAD  = 2'd1,
        REG_EFF   = 2'd2,
        REG_TRAIL = 2'd3
    } region_e;

endpackage

// File: rtl/ccd_line_tracker.sv
module ccd_line_tracker
    import ccd_blc_pkg::*;
#(
    parameter int LEAD_DUMMY  = 63,
    parameter int EFF_PIX     = 7078,
    parameter int TRAIL_DUMMY = 12,
    parameter int BLK_FIRST   = 2,
    parameter int BLK_LAST    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sol,
    output logic blk_start,
    output logic blk_en,
    output logic blk_end,
    output logic eff_en,
    output logic eff_first
);
    localparam int LINE_LEN = LEAD_DUMMY + EFF_PIX + TRAIL_DUMMY;
    localparam int POS_W    = $clog2(LINE_LEN + 1);
    localparam logic [POS_W-1:0] BLK_LO   = POS_W'(BLK_FIRST - 1);
    localparam logic [POS_W-1:0] BLK_HI   = POS_W'(BLK_LAST - 1);
    localparam logic [POS_W-1:0] EFF_LO   = POS_W'(LEAD_DUMMY);
    localparam logic [POS_W-1:0] EFF_HI   = POS_W'(LEAD_DUMMY + EFF_PIX - 1);
    localparam logic [POS_W-1:0] LAST_IDX = POS_W'(LINE_LEN - 1);

    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t             st_q, st_d;
    logic             take;
    logic [POS_W-1:0] idx;
    region_e          region;

    always_comb begin
        st_d   = st_q;
        idx    = in_sol ? '0 : st_q.pos;
        take   = in_valid && (in_sol || st_q.active);
        region = REG_IDLE;
        if (take) begin
            if (idx < EFF_LO)       region = REG_LEAD;
            else if (idx <= EFF_HI) region = REG_EFF;
            else                    region = REG_TRAIL;
            st_d.pos    = idx + 1'b1;
            st_d.active = (idx != LAST_IDX);
        end
        blk_en    = take && (idx >= BLK_LO) && (idx <= BLK_HI);
        blk_start = blk_en && (idx == BLK_LO);
        blk_end   = blk_en && (idx == BLK_HI);
        eff_en    = (region == REG_EFF);
        eff_first = eff_en && (idx == EFF_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: an open line always points inside the line, past index 0
    assert_pos_in_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.pos != '0 && st_q.pos <= LAST_IDX));

    // R8: a start flag restarts the count
    assert_sol_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> (st_q.active && st_q.pos == POS_W'(1)));

    // R9: no sample, no movement
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.pos) && $stable(st_q.active)));

endmodule

// File: rtl/ccd_black_estimator.sv
module ccd_black_estimator #(
    parameter int DATA_W = 12,
    parameter int BLK_N  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              acc_en,
    input  logic              acc_last,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] black
);
    localparam int SUM_W   = DATA_W + $clog2(BLK_N) + 1;
    localparam int X_W     = SUM_W + 2;
    localparam int CNT_W   = $clog2(BLK_N) + 1;
    localparam int SH      = X_W + CNT_W;
    localparam int RECIP_W = SH + 1;
    localparam int PROD_W  = X_W + RECIP_W;
    localparam logic [63:0] RECIP = ((64'd1 << SH) + 64'(BLK_N) - 64'd1) / 64'(BLK_N);

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] black;
    } est_t;

    est_t              st_q, st_d;
    logic [SUM_W-1:0]  total;
    logic [X_W-1:0]    x_num;
    logic [PROD_W-1:0] prod;

    always_comb begin
        st_d  = st_q;
        total = (acc_start ? '0 : st_q.sum) + SUM_W'(data);
        // round(total/N) = floor((2*total + N) / (2*N))
        x_num = {total, 1'b0} + X_W'(BLK_N);
        prod  = PROD_W'(x_num) * PROD_W'(RECIP[RECIP_W-1:0]);
        if (acc_en) begin
            st_d.sum = total;
            if (acc_last) st_d.black = DATA_W'(prod >> (SH + 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign black = st_q.black;

    // R5: the estimate only changes after the last reference sample
    assert_black_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_last |=> $stable(st_q.black));

endmodule

// File: rtl/ccd_pixel_subtract.sv
module ccd_pixel_subtract #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              pix_first,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] black,
    output logic              out_valid,
    output logic              out_sol,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic              sol;
        logic [DATA_W-1:0] data;
    } sub_t;

    sub_t            st_q, st_d;
    logic [DATA_W:0] diff;

    always_comb begin
        st_d       = st_q;
        diff       = {1'b0, data} - {1'b0, black};
        st_d.valid = pix_en;
        st_d.sol   = pix_en && pix_first;
        if (pix_en) st_d.data = diff[DATA_W] ? '0 : diff[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_sol   = st_q.sol;
    assign out_data  = st_q.data;

    // R6: subtraction never raises a pixel
    assert_sat_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.data <= $past(data)));

    // R7: start flag only travels with a valid pixel
    assert_sol_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sol |-> st_q.valid);

endmodule

// File: rtl/ccd_black_level_corrector.sv
module ccd_black_level_corrector #(
    parameter int DATA_W      = 12,
    parameter int LEAD_DUMMY  = 63,
    parameter int EFF_PIX     = 7078,
    parameter int TRAIL_DUMMY = 12,
    parameter int BLK_FIRST   = 2,
    parameter int BLK_LAST    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sol,
    output logic [DATA_W-1:0] out_data,
    output logic [DATA_W-1:0] out_black
);
    localparam int BLK_N = BLK_LAST - BLK_FIRST + 1;

    logic blk_start, blk_en, blk_end, eff_en, eff_first;

    initial begin
        assert_cfg_window_R2: assert (BLK_FIRST >= 1 && BLK_LAST < LEAD_DUMMY && BLK_N >= 1);
    end

    ccd_line_tracker #(
        .LEAD_DUMMY (LEAD_DUMMY),
        .EFF_PIX    (EFF_PIX),
        .TRAIL_DUMMY(TRAIL_DUMMY),
        .BLK_FIRST  (BLK_FIRST),
        .BLK_LAST   (BLK_LAST)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .blk_start(blk_start),
        .blk_en   (blk_en),
        .blk_end  (blk_end),
        .eff_en   (eff_en),
        .eff_first(eff_first)
    );

    ccd_black_estimator #(
        .DATA_W(DATA_W),
        .BLK_N (BLK_N)
    ) u_est (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_start(blk_start),
        .acc_en   (blk_en),
        .acc_last (blk_end),
        .data     (in_data),
        .black    (out_black)
    );

    ccd_pixel_subtract #(
        .DATA_W(DATA_W)
    ) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_en   (eff_en),
        .pix_first(eff_first),
        .data     (in_data),
        .black    (out_black),
        .out_valid(out_valid),
        .out_sol  (out_sol),
        .out_data (out_data)
    );

endmodule

// File: tb/sim_ccd_black_level_corrector.sv
module sim_ccd_black_level_corrector;
    localparam int DW    = 8;
    localparam int LEAD  = 16;
    localparam int EFF   = 20;
    localparam int TRAIL = 4;
    localparam int BF    = 2;
    localparam int BL    = 12;
    localparam int LINE  = LEAD + EFF + TRAIL;
    localparam int NB    = BL - BF + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid, out_sol;
    logic [DW-1:0] out_data, out_black;

    always #2 clk = ~clk;

    ccd_black_level_corrector #(
        .DATA_W(DW), .LEAD_DUMMY(LEAD), .EFF_PIX(EFF),
        .TRAIL_DUMMY(TRAIL), .BLK_FIRST(BF), .BLK_LAST(BL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_data(in_data), .out_valid(out_valid), .out_sol(out_sol),
        .out_data(out_data), .out_black(out_black)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R10";

    // reference model state
    bit m_active = 0;
    int m_pos = 0;
    int m_acc = 0;
    int m_black = 0;
    bit exp_valid = 0;
    bit exp_sol = 0;
    int exp_data = 0;
    int exp_black = 0;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic check_bit(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        check_bit(cur_tag, "out_valid", int'(out_valid), int'(exp_valid));
        check_bit("R3", "out_black", int'(out_black), exp_black);
        if (exp_valid) begin
            check_bit("R6", "out_data", int'(out_data), exp_data);
            check_bit("R7", "out_sol", int'(out_sol), int'(exp_sol));
        end else begin
            check_bit("R7", "out_sol idle", int'(out_sol), 0);
        end
    endtask

    task automatic step(bit v, bit sol, int d);
        bit take;
        int idx;
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_sol   = sol;
        in_data  = DW'(d);
        take = v && (sol || m_active);
        idx  = sol ? 0 : m_pos;
        exp_valid = take && idx >= LEAD && idx < LEAD + EFF;       // R2
        exp_sol   = exp_valid && idx == LEAD;                       // R7
        if (exp_valid) exp_data = (d > m_black) ? d - m_black : 0;  // R6
        if (take && idx >= BF - 1 && idx <= BL - 1) begin
            m_acc = (idx == BF - 1 ? 0 : m_acc) + d;
            if (idx == BL - 1) m_black = (2 * m_acc + NB) / (2 * NB); // R3, R4
        end
        exp_black = m_black;
        if (take) begin
            m_pos    = idx + 1;
            m_active = (idx != LINE - 1);
        end
    endtask

    task automatic send_line(int line_no, int bsum, int gap_every, int stop_at);
        for (int i = 0; i < LINE && i < stop_at; i++) begin
            int d;
            if (i >= BF - 1 && i <= BL - 1)
                d = bsum / NB + (((i - (BF - 1)) < (bsum % NB)) ? 1 : 0);
            else
                d = (i * 37 + line_no * 11) % 256;
            if (gap_every > 0 && i % gap_every == 0) step(0, 0, 255 - d); // R9
            step(1, i == 0, d);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        cur_tag = "R10";
        step(0, 0, 0);
        step(0, 0, 0);
        // R1: samples with no open line are ignored
        cur_tag = "R1";
        for (int k = 0; k < 30; k++) step(1, 0, 200);
        // R3/R6/R2: sweep of reference sums covering every remainder
        cur_tag = "R2";
        for (int s = 0; s <= NB * 255; s += 7) send_line(s, s, 0, LINE);
        send_line(1, NB * 255, 0, LINE);   // full-scale black, everything clamps
        send_line(2, 0, 0, LINE);
        // R9: gaps inside a line
        cur_tag = "R9";
        send_line(3, 600, 3, LINE);
        send_line(4, 1111, 2, LINE);
        // R1: stray samples after line end ignored
        cur_tag = "R1";
        for (int k = 0; k < 10; k++) step(1, 0, 9);
        // R8: restart mid-effective-band, then inside the reference window
        cur_tag = "R8";
        send_line(5, 900, 0, LEAD + 9);
        send_line(6, 300, 0, LINE);
        send_line(7, 2000, 0, 6);          // R5: black held from earlier line
        for (int k = 0; k < 5; k++) step(0, 0, 0);
        send_line(8, 50, 0, LINE);
        send_line(9, 1500, 0, LINE - 1);   // one short, then restart
        send_line(10, 777, 0, LINE);
        // R4/R5: black stays after line end
        cur_tag = "R5";
        for (int k = 0; k < 8; k++) step(0, 0, 0);
        finish_run();
    end

endmodule